// File: doc/BRIEF.md
# Single-Clock FIFO with Handshake, Error Flags and Fill Alarms

This block is a first-in first-out buffer that sits between a producer and a consumer running on the same clock. It absorbs bursts when the producer briefly outpaces the consumer. Every request is answered in the cycle after the clock edge that samples it. An accepted write returns a write acknowledge. An accepted read returns an acknowledge together with the data word. A request that cannot be served returns an error pulse and is not dropped without notice.

Two fill alarms compare the occupancy against thresholds driven on input ports. One warns that the buffer is nearly full and the other that it is nearly drained. An interrupt line combines the two alarms with the two error pulses. The depth must be a power of two. The read and write pointers each carry one extra wrap bit, so a full buffer and an empty buffer can be told apart without a separate counter.

Top module: `sync_fifo_flagged`

## Requirements
- R1: While `rst_n` is low, the buffer is empty: `empty`=1, `full`=0, `level`=0, and every acknowledge, error, alarm and `irq` output is 0.
- R2: A write request taken while not full stores `wr_data`. `wr_ack` is then high for exactly the one cycle after that edge, and `level` rises by one in the same cycle.
- R3: A write request taken while full is refused. `wr_err` is high for the one cycle after that edge and `wr_ack` stays low. Stored data and `level` are unchanged.
- R4: A read request taken while empty is refused. `rd_err` is high for the one cycle after that edge and `rd_ack` stays low. Stored data and `level` are unchanged.
- R5: Accepted reads return words in the order they were written. `rd_data` holds the word in the same cycle that `rd_ack` is high.
- R6: Whether a request is accepted depends on the state before the edge. A read and a write in the same cycle while neither full nor empty are both accepted, and `level` stays the same. At full only the read is accepted. At empty only the write is accepted.
- R7: `level` equals the number of stored words, from 0 to DEPTH. `full` is 1 exactly when `level` equals DEPTH, and `empty` is 1 exactly when `level` is 0.
- R8: `hi_mark` is 1 exactly when `level` is at or above `hi_thr`. It is updated in the same cycle as `level`, and a threshold change shows after one edge.
- R9: `lo_mark` is 1 exactly when `level` is at or below `lo_thr`, with the same timing as R8.
- R10: `irq` is the OR of `wr_err`, `rd_err`, `hi_mark` and `lo_mark`, and it is valid in the same cycle as those flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| hi_thr | input | $clog2(DEPTH)+1 | Upper alarm threshold |
| lo_thr | input | $clog2(DEPTH)+1 | Lower alarm threshold |
| wr_ack | output | 1 | Write accepted (one-cycle pulse) |
| wr_err | output | 1 | Write refused because full (one-cycle pulse) |
| rd_ack | output | 1 | Read accepted, `rd_data` valid (one-cycle pulse) |
| rd_err | output | 1 | Read refused because empty (one-cycle pulse) |
| rd_data | output | DATA_W | Word returned by the last accepted read |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| level | output | $clog2(DEPTH)+1 | Current occupancy |
| hi_mark | output | 1 | Occupancy at or above `hi_thr` |
| lo_mark | output | 1 | Occupancy at or below `lo_thr` |
| irq | output | 1 | OR of both errors and both alarms |

## Verification
Every result of a request is due one clock edge after the request is sampled: acknowledges, errors, read data, `level`, `full`, `empty`, both alarms and `irq`. A threshold change likewise shows after one edge. The bench drives requests at the falling edge and samples all outputs 2 ns after the next rising edge. It compares them against a queue model and against occupancy arithmetic updated for that same edge. The reset state is sampled while reset is still held, because the reset acts asynchronously.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

    // Transfers granted at the current edge
    typedef struct packed {
        logic wr_go;
        logic rd_go;
    } sfq_xfer_t;

    // Refused requests at the current edge
    typedef struct packed {
        logic wr_err;
        logic rd_err;
    } sfq_err_t;

endpackage

// File: rtl/sfq_ctrl.sv
module sfq_ctrl
    import sfq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    output sfq_xfer_t     xfer,
    output sfq_err_t      err_nxt,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic [CW-1:0] level_q,
    output logic [CW-1:0] level_d,
    output logic          full,
    output logic          empty,
    output logic          wr_ack,
    output logic          rd_ack,
    output logic          wr_err,
    output logic          rd_err
);

    typedef struct packed {
        logic [CW-1:0] wptr;
        logic [CW-1:0] rptr;
        logic          wr_ack;
        logic          rd_ack;
        logic          wr_err;
        logic          rd_err;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        full  = (st_q.wptr[AW] != st_q.rptr[AW]) &&
                (st_q.wptr[AW-1:0] == st_q.rptr[AW-1:0]);
        empty = (st_q.wptr == st_q.rptr);

        xfer.wr_go     = wr_req && !full;
        xfer.rd_go     = rd_req && !empty;
        err_nxt.wr_err = wr_req && full;
        err_nxt.rd_err = rd_req && empty;

        st_d        = st_q;
        st_d.wptr   = st_q.wptr + {{AW{1'b0}}, xfer.wr_go};
        st_d.rptr   = st_q.rptr + {{AW{1'b0}}, xfer.rd_go};
        st_d.wr_ack = xfer.wr_go;
        st_d.rd_ack = xfer.rd_go;
        st_d.wr_err = err_nxt.wr_err;
        st_d.rd_err = err_nxt.rd_err;

        level_q = st_q.wptr - st_q.rptr;
        level_d = st_d.wptr - st_d.rptr;
        waddr   = st_q.wptr[AW-1:0];
        raddr   = st_q.rptr[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ack = st_q.wr_ack;
    assign rd_ack = st_q.rd_ack;
    assign wr_err = st_q.wr_err;
    assign rd_err = st_q.rd_err;

    // R3: refused write raises only the error
    a_r3_full_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req) |=> (wr_err && !wr_ack));
    // R4: refused read raises only the error
    a_r4_empty_read_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req) |=> (rd_err && !rd_ack));
    // R3: refused lone write leaves occupancy alone
    a_r3_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !rd_req) |=> $stable(level_q));
    // R6: paired transfer in the middle keeps occupancy
    a_r6_pair_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && !empty && wr_req && rd_req) |=> ($stable(level_q) && wr_ack && rd_ack));
    // R7: occupancy bounded, flags exclusive
    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q <= CW'(DEPTH)) && !(full && empty));

endmodule

// File: rtl/sfq_store.sv
module sfq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            rdata;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.mem[waddr] = wdata;
        if (re) st_d.rdata = st_q.mem[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    // R5: output word only moves on an accepted read
    a_r5_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));

endmodule

// File: rtl/sfq_marks.sv
module sfq_marks
    import sfq_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] level_nxt,
    input  logic [CW-1:0] hi_thr,
    input  logic [CW-1:0] lo_thr,
    input  sfq_err_t      err_nxt,
    output logic          hi_mark,
    output logic          lo_mark,
    output logic          irq
);

    typedef struct packed {
        logic hi;
        logic lo;
        logic irq;
    } marks_st_t;

    marks_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.hi  = (level_nxt >= hi_thr);
        st_d.lo  = (level_nxt <= lo_thr);
        st_d.irq = err_nxt.wr_err || err_nxt.rd_err || st_d.hi || st_d.lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_mark = st_q.hi;
    assign lo_mark = st_q.lo;
    assign irq     = st_q.irq;

    // R8: upper alarm follows the coming occupancy
    a_r8_hi_set: assert property (@(posedge clk) disable iff (!rst_n)
        (level_nxt >= hi_thr) |=> hi_mark);
    a_r8_hi_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (level_nxt < hi_thr) |=> !hi_mark);
    // R9: lower alarm follows the coming occupancy
    a_r9_lo_set: assert property (@(posedge clk) disable iff (!rst_n)
        (level_nxt <= lo_thr) |=> lo_mark);
    // R10: any error or alarm drives the interrupt
    a_r10_irq_err: assert property (@(posedge clk) disable iff (!rst_n)
        (err_nxt.wr_err || err_nxt.rd_err) |=> irq);
    a_r10_irq_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_mark || lo_mark) |-> irq);

endmodule

// File: rtl/sync_fifo_flagged.sv
module sync_fifo_flagged
    import sfq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [CW-1:0]     hi_thr,
    input  logic [CW-1:0]     lo_thr,
    output logic              wr_ack,
    output logic              wr_err,
    output logic              rd_ack,
    output logic              rd_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic [CW-1:0]     level,
    output logic              hi_mark,
    output logic              lo_mark,
    output logic              irq
);

    sfq_xfer_t     xfer;
    sfq_err_t      err_nxt;
    logic [AW-1:0] waddr, raddr;
    logic [CW-1:0] level_d;

    sfq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_en),
        .rd_req  (rd_en),
        .xfer    (xfer),
        .err_nxt (err_nxt),
        .waddr   (waddr),
        .raddr   (raddr),
        .level_q (level),
        .level_d (level_d),
        .full    (full),
        .empty   (empty),
        .wr_ack  (wr_ack),
        .rd_ack  (rd_ack),
        .wr_err  (wr_err),
        .rd_err  (rd_err)
    );

    sfq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (xfer.wr_go),
        .waddr (waddr),
        .wdata (wr_data),
        .re    (xfer.rd_go),
        .raddr (raddr),
        .rdata (rd_data)
    );

    sfq_marks #(.CW(CW)) marks_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_nxt (level_d),
        .hi_thr    (hi_thr),
        .lo_thr    (lo_thr),
        .err_nxt   (err_nxt),
        .hi_mark   (hi_mark),
        .lo_mark   (lo_mark),
        .irq       (irq)
    );

endmodule

// File: tb/sync_fifo_flagged_tb_top.sv
module sync_fifo_flagged_tb_top;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 8;
    localparam int CW     = $clog2(DEPTH) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [CW-1:0]     hi_thr = '0;
    logic [CW-1:0]     lo_thr = '0;
    logic              wr_ack, wr_err, rd_ack, rd_err, full, empty;
    logic              hi_mark, lo_mark, irq;
    logic [DATA_W-1:0] rd_data;
    logic [CW-1:0]     level;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int mq[$];

    always #4 clk = ~clk;

    sync_fifo_flagged #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .hi_thr(hi_thr), .lo_thr(lo_thr),
        .wr_ack(wr_ack), .wr_err(wr_err), .rd_ack(rd_ack), .rd_err(rd_err),
        .rd_data(rd_data), .full(full), .empty(empty), .level(level),
        .hi_mark(hi_mark), .lo_mark(lo_mark), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge; one request cycle, checked after the edge
    task automatic step(input bit we, input int wd, input bit re);
        bit aw, ar, pair;
        int cnt, exp_rd;
        cnt  = mq.size();
        aw   = we && (cnt < DEPTH);
        ar   = re && (cnt > 0);
        pair = we && re;
        exp_rd = 0;
        wr_en = we; wr_data = DATA_W'(wd); rd_en = re;
        @(posedge clk); #2;
        if (ar) exp_rd = mq.pop_front();
        if (aw) mq.push_back(wd & 8'hFF);
        cnt = mq.size();
        chk(pair ? "R6 wr_ack" : "R2 wr_ack", int'(wr_ack), int'(aw));
        chk("R3 wr_err", int'(wr_err), int'(we && !aw));
        chk("R4 rd_err", int'(rd_err), int'(re && !ar));
        chk(pair ? "R6 rd_ack" : "R5 rd_ack", int'(rd_ack), int'(ar));
        if (ar) chk("R5 rd_data", int'(rd_data), exp_rd);
        chk(pair ? "R6 level" : "R7 level", int'(level), cnt);
        chk("R7 full", int'(full), int'(cnt == DEPTH));
        chk("R7 empty", int'(empty), int'(cnt == 0));
        chk("R8 hi_mark", int'(hi_mark), int'(cnt >= int'(hi_thr)));
        chk("R9 lo_mark", int'(lo_mark), int'(cnt <= int'(lo_thr)));
        chk("R10 irq", int'(irq), int'((we && !aw) || (re && !ar) ||
                                       cnt >= int'(hi_thr) || cnt <= int'(lo_thr)));
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        mq.delete();
        // R1: reset state while reset held
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 level", int'(level), 0);
        chk("R1 flags", int'({wr_ack, wr_err, rd_ack, rd_err}), 0);
        chk("R1 marks", int'({hi_mark, lo_mark, irq}), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        hi_thr = CW'(6); lo_thr = CW'(2);
        do_reset();

        // R2/R3: fill past full, then one more refused write
        for (int i = 0; i < DEPTH + 2; i++) step(1'b1, i * 37 + 5, 1'b0);
        // R6: pair at full: read taken, write refused
        step(1'b1, 8'hEE, 1'b1);
        // R5/R4: drain past empty
        for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 0, 1'b1);
        // R6: pair at empty: write taken, read refused
        step(1'b1, 8'h5A, 1'b1);
        // mixed traffic pattern
        for (int i = 0; i < 60; i++)
            step((i % 3) != 0, i * 11 + 3, (i % 2) == 0 || (i % 7) == 0);
        // R6: sustained pairs at each middle occupancy
        for (int l = 1; l < DEPTH; l++) begin
            while (mq.size() < l) step(1'b1, l * 13, 1'b0);
            while (mq.size() > l) step(1'b0, 0, 1'b1);
            for (int k = 0; k < 3; k++) step(1'b1, l * 29 + k, 1'b1);
        end
        // R8/R9: sweep thresholds over a full fill and drain
        for (int h = 0; h <= DEPTH + 1; h++) begin
            hi_thr = CW'(h);
            lo_thr = CW'(DEPTH - h < 0 ? 0 : DEPTH - h);
            while (mq.size() > 0) step(1'b0, 0, 1'b1);
            step(1'b0, 0, 1'b0);
            for (int i = 0; i <= DEPTH; i++) step(1'b1, h * 17 + i, 1'b0);
            for (int i = 0; i <= DEPTH; i++) step(1'b0, 0, 1'b1);
        end
        // R1: reset while holding data
        for (int i = 0; i < 5; i++) step(1'b1, i + 100, 1'b0);
        do_reset();
        @(negedge clk);
        step(1'b0, 0, 1'b1);
        step(1'b1, 8'h77, 1'b0);
        step(1'b0, 0, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule